// File: doc/BRIEF.md
# Flash Program Write Buffer

This block stages one line of program data for a NOR-style flash array model and then commits it. A host writes 16-bit words into a 256-entry volatile buffer at any word offset, in any order. A write to the same offset replaces the earlier value. A commit strobe names a target line. The block then walks the buffer one word per clock and ANDs each buffer word into the matching array word. Because of the AND, a commit can only clear bits. Buffer words that were never written are still all ones, so they leave the array untouched. As each word is consumed, its buffer slot returns to all ones. This leaves the buffer ready for the next line.

A separate erase strobe names a sector, which is a group of aligned lines. The block sets every word in that sector back to all ones, one word per clock. Erase does not touch the staging buffer. The busy output covers both operations, and done pulses for one cycle when an operation finishes. Buffer writes that arrive while busy is high are dropped and raise a sticky error flag. A combinational read port exposes any array word. Array addresses are formed as {sector, line within sector, word offset}, with the word offset in the low bits.

Top module: `pgm_line_buffer`

## Requirements
- R1: After reset, busy, done and wr_err are 0, and every buffer word is 16'hFFFF. A commit issued with no prior writes therefore leaves the target line unchanged, even if writes were made before the reset.
- R2: While busy is low, a wr_valid cycle stores wr_data at buffer offset wr_off, which is the low 8 word-address bits. A later write to the same offset replaces the earlier value.
- R3: A commit strobe sampled while idle raises busy on the next cycle. Busy then stays high for exactly 256 cycles, and done is high for exactly one cycle immediately after busy falls.
- R4: A commit makes each word of the target line equal to its previous value ANDed with the buffer word at the same offset. No array bit ever goes from 0 to 1 during a commit.
- R5: Buffer offsets not written since the buffer was last cleared hold 16'hFFFF and leave the corresponding array words unchanged.
- R6: When a commit completes, every buffer word is 16'hFFFF again. A following commit with no writes leaves its target line unchanged.
- R7: An erase strobe sampled while idle sets every word of the selected sector (2 lines, 512 words) to 16'hFFFF. Busy stays high for 512 cycles, followed by a one-cycle done. Words in the other sector are not changed.
- R8: An erase leaves the staging buffer contents intact, so a commit after the erase still writes the earlier buffer data.
- R9: A wr_valid cycle while busy is high does not change the buffer, and wr_err is 1 from the next cycle on. wr_err stays 1 until reset. Writes made while idle never set wr_err.
- R10: Commit and erase strobes sampled while busy is high are ignored. If both are asserted together while idle, the commit is performed and the erase is discarded.
- R11: cmt_line selects line {sector, line within sector}, ers_sector selects the sector, and rd_data returns the array word at {rd_line, rd_off}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Buffer write enable |
| wr_off | input | 8 | Word offset within the line |
| wr_data | input | 16 | Word to store in the buffer |
| commit | input | 1 | Start a commit of the buffer into a line |
| cmt_line | input | 2 | Target line index for the commit |
| erase | input | 1 | Start a sector erase |
| ers_sector | input | 1 | Target sector for the erase |
| busy | output | 1 | Commit or erase in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| wr_err | output | 1 | Sticky flag: a buffer write arrived while busy |
| rd_line | input | 2 | Line index for array read-back |
| rd_off | input | 8 | Word offset for array read-back |
| rd_data | output | 16 | Array word at the read address |

## Verification
Some properties are checked by assertions on every cycle:
- No array bit is ever set by a commit step, and every erase step leaves its word all ones.
- A consumed buffer slot returns to all ones, and an accepted write lands at its offset.
- The operation counter advances by one per cycle, and done follows the last step as a single pulse.
- The latched target is held steady while busy, and wr_err is sticky.

Other behaviour only the bench scenarios can show:
- The exact busy lengths of 256 and 512 cycles.
- That dropped writes and strobes never reach the array, and that the buffer survives an erase.
- The full AND result across all 256 words of a line.
- That commit wins over erase when both arrive together.

// File: rtl/plb_pkg.sv
package plb_pkg;

   typedef enum logic [1:0] {
      PLB_IDLE  = 2'd0,
      PLB_PROG  = 2'd1,
      PLB_ERASE = 2'd2
   } plb_state_e;

endpackage

// File: rtl/plb_word_store.sv
module plb_word_store #(
   parameter int WORD_W = 16,
   parameter int OFF_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [OFF_W-1:0]  clr_off,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [WORD_W-1:0] rd_data
);
   localparam int DEPTH = 1 << OFF_W;

   logic [WORD_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '1;
      end else if (clr_en) begin
         slot_q[clr_off] <= '1;
      end else if (wr_en) begin
         slot_q[wr_off] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_off];

   // R6: a consumed slot is back to all ones on the next cycle
   p_clr_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> (slot_q[$past(clr_off)] == '1));

   // R2: an accepted write lands at its offset
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_en) |=> (slot_q[$past(wr_off)] == $past(wr_data)));

endmodule

// File: rtl/plb_cell_array.sv
module plb_cell_array #(
   parameter int WORD_W = 16,
   parameter int AW     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_prog,
   input  logic              op_erase,
   input  logic [AW-1:0]     op_addr,
   input  logic [WORD_W-1:0] op_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   localparam int WORDS = 1 << AW;

   logic [WORD_W-1:0] cell_q [WORDS];
   logic [WORD_W-1:0] cur_w;

   always_ff @(posedge clk) begin
      if (op_prog) begin
         cell_q[op_addr] <= cell_q[op_addr] & op_data;
      end else if (op_erase) begin
         cell_q[op_addr] <= '1;
      end
   end

   assign rd_data = cell_q[rd_addr];
   assign cur_w   = cell_q[op_addr];

   // R4: a commit step never turns a 0 into a 1
   p_prog_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_prog |=> ((cell_q[$past(op_addr)] & ~$past(cur_w)) == '0));

   // R7: an erase step leaves the word all ones
   p_erase_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_erase |=> (cell_q[$past(op_addr)] == '1));

endmodule

// File: rtl/plb_seq.sv
module plb_seq
   import plb_pkg::*;
#(
   parameter int OFF_W  = 8,
   parameter int SL_W   = 1,
   parameter int SEC_W  = 1,
   localparam int LINE_W = SEC_W + SL_W,
   localparam int CNT_W  = SL_W + OFF_W,
   localparam int AW     = LINE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              erase_i,
   input  logic [SEC_W-1:0]  sec_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              op_prog_o,
   output logic              op_erase_o,
   output logic [AW-1:0]     op_addr_o,
   output logic [OFF_W-1:0]  buf_off_o
);
   plb_state_e        state_q;
   logic [CNT_W-1:0]  idx_q;
   logic [LINE_W-1:0] tgt_line_q;
   logic [SEC_W-1:0]  tgt_sec_q;
   logic              done_q;
   logic              prog_last, erase_last;

   assign prog_last  = (idx_q[OFF_W-1:0] == {OFF_W{1'b1}});
   assign erase_last = (idx_q == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PLB_IDLE;
         idx_q      <= '0;
         tgt_line_q <= '0;
         tgt_sec_q  <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            PLB_IDLE: begin
               idx_q <= '0;
               if (commit_i) begin
                  state_q    <= PLB_PROG;
                  tgt_line_q <= line_i;
               end else if (erase_i) begin
                  state_q   <= PLB_ERASE;
                  tgt_sec_q <= sec_i;
               end
            end
            PLB_PROG: begin
               if (prog_last) begin
                  state_q <= PLB_IDLE;
                  done_q  <= 1'b1;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PLB_ERASE: begin
               if (erase_last) begin
                  state_q <= PLB_IDLE;
                  done_q  <= 1'b1;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= PLB_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != PLB_IDLE);
   assign done_o     = done_q;
   assign op_prog_o  = (state_q == PLB_PROG);
   assign op_erase_o = (state_q == PLB_ERASE);
   assign buf_off_o  = idx_q[OFF_W-1:0];
   assign op_addr_o  = op_prog_o ? {tgt_line_q, idx_q[OFF_W-1:0]} : {tgt_sec_q, idx_q};

   // R3: done is a single-cycle pulse
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R3: the last commit step is followed by done and idle
   p_prog_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_prog_o && prog_last) |=> (done_q && !busy_o));

   // R3: one word per clock during a commit
   p_prog_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_prog_o && !prog_last) |=> (op_prog_o && idx_q == $past(idx_q) + 1'b1));

   // R10: strobes during an operation do not retarget it
   p_hold_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(tgt_line_q) && $stable(tgt_sec_q)));

endmodule

// File: rtl/pgm_line_buffer.sv
module pgm_line_buffer #(
   parameter int WORD_W = 16,
   parameter int OFF_W  = 8,
   parameter int SL_W   = 1,
   parameter int SEC_W  = 1,
   localparam int LINE_W = SEC_W + SL_W,
   localparam int AW     = LINE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              commit,
   input  logic [LINE_W-1:0] cmt_line,
   input  logic              erase,
   input  logic [SEC_W-1:0]  ers_sector,
   output logic              busy,
   output logic              done,
   output logic              wr_err,
   input  logic [LINE_W-1:0] rd_line,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [WORD_W-1:0] rd_data
);
   if (WORD_W < 1 || WORD_W > 64) begin : g_bad_word
      $error("pgm_line_buffer: WORD_W out of range");
   end
   if (OFF_W < 1 || OFF_W > 10) begin : g_bad_off
      $error("pgm_line_buffer: OFF_W out of range");
   end
   if (SL_W < 0 || SEC_W < 1 || AW > 12) begin : g_bad_geom
      $error("pgm_line_buffer: array geometry too large");
   end

   logic              op_prog, op_erase, wr_en, err_q;
   logic [AW-1:0]     op_addr;
   logic [OFF_W-1:0]  buf_off;
   logic [WORD_W-1:0] buf_word;

   assign wr_en = wr_valid & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                err_q <= 1'b0;
      else if (wr_valid && busy) err_q <= 1'b1;
   end
   assign wr_err = err_q;

   plb_seq #(.OFF_W(OFF_W), .SL_W(SL_W), .SEC_W(SEC_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .line_i     (cmt_line),
      .erase_i    (erase),
      .sec_i      (ers_sector),
      .busy_o     (busy),
      .done_o     (done),
      .op_prog_o  (op_prog),
      .op_erase_o (op_erase),
      .op_addr_o  (op_addr),
      .buf_off_o  (buf_off)
   );

   plb_word_store #(.WORD_W(WORD_W), .OFF_W(OFF_W)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_off  (wr_off),
      .wr_data (wr_data),
      .clr_en  (op_prog),
      .clr_off (buf_off),
      .rd_off  (buf_off),
      .rd_data (buf_word)
   );

   plb_cell_array #(.WORD_W(WORD_W), .AW(AW)) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_prog  (op_prog),
      .op_erase (op_erase),
      .op_addr  (op_addr),
      .op_data  (buf_word),
      .rd_addr  ({rd_line, rd_off}),
      .rd_data  (rd_data)
   );

   // R9: the error flag is sticky
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R9: a write while busy raises the flag
   p_busy_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && busy) |=> err_q);

endmodule

// File: tb/pgm_line_buffer_tb_top.sv
module pgm_line_buffer_tb_top;
   localparam int LINES = 4;
   localparam int LW    = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_off = '0;
   logic [15:0] wr_data = '0;
   logic        commit = 1'b0;
   logic [1:0]  cmt_line = '0;
   logic        erase = 1'b0;
   logic [0:0]  ers_sector = '0;
   logic        busy, done, wr_err;
   logic [1:0]  rd_line = '0;
   logic [7:0]  rd_off = '0;
   logic [15:0] rd_data;

   int total = 0;
   int fails = 0;

   logic [15:0] mdl  [LINES][LW];
   logic [15:0] mbuf [LW];

   typedef struct {
      logic [15:0] exp;
      int          line;
      int          off;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q [$];

   always #5 clk = ~clk;

   pgm_line_buffer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_off(wr_off),
      .wr_data(wr_data), .commit(commit), .cmt_line(cmt_line),
      .erase(erase), .ers_sector(ers_sector), .busy(busy), .done(done),
      .wr_err(wr_err), .rd_line(rd_line), .rd_off(rd_off), .rd_data(rd_data)
   );

   // monitor: pops expected read-back words and compares
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         total++;
         if (rd_data !== it.exp) begin
            fails++;
            $display("FAIL %s line %0d off %0d act=%h exp=%h",
                     it.tag, it.line, it.off, rd_data, it.exp);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_buf_model();
      for (int k = 0; k < LW; k++) mbuf[k] = 16'hFFFF;
   endtask

   task automatic buf_write(input int off, input logic [15:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_off = 8'(off); wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      mbuf[off] = d;
   endtask

   task automatic check_line(input int line, input string tag);
      for (int k = 0; k < LW; k++) begin
         sb_item_t it;
         @(posedge clk); #1;
         rd_line = 2'(line); rd_off = 8'(k);
         it.exp = mdl[line][k]; it.line = line; it.off = k; it.tag = tag;
         sb_q.push_back(it);
      end
      @(posedge clk); #1;
   endtask

   task automatic run_op(input bit do_c, input bit do_e, input int line, input int sec,
                         input bit inject, output int bcnt, output int dcnt);
      @(negedge clk);
      commit = do_c; erase = do_e; cmt_line = 2'(line); ers_sector = 1'(sec);
      @(negedge clk);
      commit = 1'b0; erase = 1'b0;
      bcnt = 0; dcnt = 0;
      for (int i = 0; i < 3000; i++) begin
         if (busy) bcnt++;
         if (done) begin dcnt++; break; end
         if (inject && bcnt == 10) begin
            wr_valid = 1'b1; wr_off = 8'd20; wr_data = 16'h0000;
            erase = 1'b1; ers_sector = 1'b1; commit = 1'b1; cmt_line = 2'd0;
         end else begin
            wr_valid = 1'b0; erase = 1'b0; commit = 1'b0;
         end
         @(negedge clk);
      end
      wr_valid = 1'b0; erase = 1'b0; commit = 1'b0;
      @(negedge clk);
      if (done) dcnt++;
   endtask

   task automatic model_commit(input int line);
      for (int k = 0; k < LW; k++) mdl[line][k] = mdl[line][k] & mbuf[k];
      clr_buf_model();
   endtask

   task automatic model_erase(input int sec);
      for (int l = sec * 2; l < sec * 2 + 2; l++)
         for (int k = 0; k < LW; k++) mdl[l][k] = 16'hFFFF;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", total, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL R3 watchdog expired act=0 exp=1");
      summary();
      $finish;
   end

   initial begin
      int bc, dc;
      clr_buf_model();
      for (int l = 0; l < LINES; l++)
         for (int k = 0; k < LW; k++) mdl[l][k] = 16'hFFFF;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      chk(wr_err == 1'b0, "R1 wr_err after reset", int'(wr_err), 0);

      // R7: erase both sectors, 512 busy cycles each
      run_op(1'b0, 1'b1, 0, 0, 1'b0, bc, dc);
      chk(bc == 512, "R7 erase busy length", bc, 512);
      chk(dc == 1, "R7 erase done pulse", dc, 1);
      run_op(1'b0, 1'b1, 0, 1, 1'b0, bc, dc);
      for (int l = 0; l < LINES; l++) check_line(l, "R7 erased line");

      // R1/R3/R5: empty commit
      run_op(1'b1, 1'b0, 0, 0, 1'b0, bc, dc);
      chk(bc == 256, "R3 commit busy length", bc, 256);
      chk(dc == 1, "R3 commit done pulse", dc, 1);
      model_commit(0);
      check_line(0, "R5 empty commit line0");

      // R2/R4/R11: pattern into line 1, last write wins at offset 5
      buf_write(0, 16'h1234);
      buf_write(255, 16'hA5A5);
      buf_write(5, 16'h0F0F);
      buf_write(5, 16'h00FF);
      buf_write(130, 16'h0000);
      run_op(1'b1, 1'b0, 1, 0, 1'b0, bc, dc);
      model_commit(1);
      check_line(1, "R2 R11 pattern line1");

      // R4: second pattern ANDs with existing line contents
      buf_write(0, 16'hFF00);
      buf_write(5, 16'hFFFF);
      buf_write(7, 16'h5555);
      run_op(1'b1, 1'b0, 1, 0, 1'b0, bc, dc);
      model_commit(1);
      check_line(1, "R4 and-merge line1");

      // R6: buffer cleared after commit
      run_op(1'b1, 1'b0, 2, 0, 1'b0, bc, dc);
      model_commit(2);
      check_line(2, "R6 refilled buffer line2");

      // R9/R10: write and strobes during busy are dropped
      buf_write(9, 16'h0000);
      chk(wr_err == 1'b0, "R9 idle write no error", int'(wr_err), 0);
      run_op(1'b1, 1'b0, 3, 0, 1'b1, bc, dc);
      chk(bc == 256, "R10 busy length with stray strobes", bc, 256);
      chk(wr_err == 1'b1, "R9 error after busy write", int'(wr_err), 1);
      model_commit(3);
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R10 no extra op started", int'(busy), 0);
      check_line(3, "R9 R10 dropped write line3");
      chk(wr_err == 1'b1, "R9 error sticky", int'(wr_err), 1);

      // R8: erase keeps buffer contents
      buf_write(3, 16'h1111);
      run_op(1'b0, 1'b1, 0, 1, 1'b0, bc, dc);
      model_erase(1);
      run_op(1'b1, 1'b0, 2, 0, 1'b0, bc, dc);
      model_commit(2);
      check_line(2, "R8 buffer kept across erase");
      check_line(3, "R7 erased sector1 line3");
      check_line(1, "R7 other sector intact");

      // R10: commit wins over simultaneous erase
      buf_write(1, 16'h0000);
      run_op(1'b1, 1'b1, 3, 0, 1'b0, bc, dc);
      chk(bc == 256, "R10 commit priority length", bc, 256);
      model_commit(3);
      check_line(3, "R10 commit priority line3");
      check_line(0, "R10 erase discarded line0");

      // R1: reset clears buffer and error
      buf_write(50, 16'h0000);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      clr_buf_model();
      @(negedge clk);
      chk(wr_err == 1'b0, "R9 R1 error cleared by reset", int'(wr_err), 0);
      run_op(1'b1, 1'b0, 2, 0, 1'b0, bc, dc);
      model_commit(2);
      check_line(2, "R1 buffer ones after reset");

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule